// File: doc/BRIEF.md
# Branch and Indexed Address Generator

This block produces the next program counter and the data effective address for a 16-bit core whose instructions are one 16-bit word each. Each valid request carries an operation code. A sequential step advances the PC by two. A conditional branch adds a 9-bit signed word offset to PC+2, but only when the selected flag condition holds. An unconditional branch adds a 10-bit signed word offset to PC+2. An indexed load or store adds a 5-bit unsigned offset to a base register. For the indexed case the block also reports the access size and a misalignment flag.

Results are registered once. A request presented in one cycle appears on the outputs after the next rising clock edge. The memory access itself is done elsewhere.

Top module: `agu_top`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every output is zero until the first valid request has been registered.
- R2: When `op_i`=1 (conditional branch) and the condition holds, `next_pc_o` = `pc_i` + 2 + (sign-extended `offset_i[8:0]` << 1). `offset_i[9]` has no effect in this case. `taken_o` is 1.
- R3: When `op_i`=1 and the condition does not hold, `next_pc_o` = `pc_i` + 2 and `taken_o` is 0.
- R4: The flag bits are `flags_i` = {N, Z, V, C} (bit 3 down to bit 0). `cond_sel_i` chooses the condition as follows: 0 gives C=0, 1 gives C=1, 2 gives Z=0, 3 gives Z=1, 4 gives N=0, 5 gives N=1, 6 gives V=0, 7 gives V=1.
- R5: When `op_i`=2 (unconditional branch), `next_pc_o` = `pc_i` + 2 + (sign-extended `offset_i[9:0]` << 1) and `taken_o` is 1, whatever the flags and selector are.
- R6: When `op_i`=3 (indexed access), `ea_o` = `base_i` + zero-extended `offset_i[4:0]`, `offset_i[9:5]` has no effect, `next_pc_o` = `pc_i` + 2, and `taken_o` is 0.
- R7: For `op_i`=3, `ea_word_o` copies `size_word_i` (1 = word, 0 = byte). `misalign_o` is 1 exactly when this is a word access and `ea_o[0]` is 1.
- R8: All address arithmetic wraps modulo 2^16.
- R9: Outputs change one clock edge after a request with `valid_i`=1, and `valid_o` follows `valid_i` with the same delay. While `valid_i` is 0, the address outputs hold their values.
- R10: When `op_i`=0 (sequential), `next_pc_o` = `pc_i` + 2. For every `op_i` other than 3, `ea_o`, `ea_word_o` and `misalign_o` are 0, and `taken_o` is 0 for `op_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request valid |
| op_i | input | 2 | 0 sequential, 1 conditional branch, 2 unconditional branch, 3 indexed access |
| pc_i | input | 16 | Current PC |
| offset_i | input | 10 | Offset field from the instruction |
| flags_i | input | 4 | {N, Z, V, C} |
| cond_sel_i | input | 3 | Branch condition selector |
| base_i | input | 16 | Base register value |
| size_word_i | input | 1 | 1 word access, 0 byte access |
| valid_o | output | 1 | Result valid |
| next_pc_o | output | 16 | Next PC |
| taken_o | output | 1 | Branch taken |
| ea_o | output | 16 | Effective address |
| ea_word_o | output | 1 | Size tag of the access |
| misalign_o | output | 1 | Word access at an odd address |

## Verification
The bench builds the block with its default widths: a 16-bit address, a 9-bit short offset, a 10-bit long offset and a 5-bit index offset. With these widths the extreme offsets, -256/+255 words and -512/+511 words, can be reached directly. They push the targets across the 0x0000/0xFFFF boundary, so the wrap case is exercised. The full 5-bit index range 0..31 can also be driven with the unused upper offset bits set, and all eight condition codes can be combined with flag values that make them true and false.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    OP_SEQ  = 2'd0,
    OP_BCC  = 2'd1,
    OP_BRA  = 2'd2,
    OP_MEM  = 2'd3
  } agu_op_e;

  typedef enum logic [2:0] {
    CC_CCLR = 3'd0,
    CC_CSET = 3'd1,
    CC_ZCLR = 3'd2,
    CC_ZSET = 3'd3,
    CC_NCLR = 3'd4,
    CC_NSET = 3'd5,
    CC_VCLR = 3'd6,
    CC_VSET = 3'd7
  } agu_cond_e;

  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_V = 1;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_N = 3;
endpackage

// File: rtl/agu_cond.sv
module agu_cond
  import agu_pkg::*;
(
  input  logic [3:0] flags_i,
  input  logic [2:0] cond_sel_i,
  output logic       cond_o
);
  logic flag_sel;

  // low bit picks polarity, upper bits pick flag
  always_comb begin
    unique case (cond_sel_i[2:1])
      2'd0:    flag_sel = flags_i[FLAG_C];
      2'd1:    flag_sel = flags_i[FLAG_Z];
      2'd2:    flag_sel = flags_i[FLAG_N];
      default: flag_sel = flags_i[FLAG_V];
    endcase
  end

  assign cond_o = cond_sel_i[0] ? flag_sel : ~flag_sel;
endmodule

// File: rtl/agu_rel.sv
module agu_rel #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 9
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W - 1;

  logic [ADDR_W-1:0] disp;

  // word offset -> byte displacement, sign extended
  generate
    if (EXT_W > 0) begin : g_ext
      assign disp = {{EXT_W{off_i[OFF_W-1]}}, off_i, 1'b0};
    end else begin : g_trunc
      assign disp = {off_i[ADDR_W-2:0], 1'b0};
    end
  endgenerate

  assign target_o = pc_i + ADDR_W'(2) + disp;
endmodule

// File: rtl/agu_idx.sv
module agu_idx #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = 5
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  off_i,
  input  logic              word_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              misalign_o
);
  assign ea_o       = base_i + {{(ADDR_W-IDX_W){1'b0}}, off_i};
  assign misalign_o = word_i & ea_o[0];
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SREL_W  = 9,
  parameter int unsigned LREL_W  = 10,
  parameter int unsigned IDX_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [LREL_W-1:0] offset_i,
  input  logic [3:0]        flags_i,
  input  logic [2:0]        cond_sel_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              size_word_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic              ea_word_o,
  output logic              misalign_o
);
  logic              cond_ok;
  logic [ADDR_W-1:0] seq_pc, short_pc, long_pc, idx_ea;
  logic              idx_mis;
  logic [ADDR_W-1:0] pc_d, ea_d;
  logic              taken_d, word_d, mis_d;

  agu_cond u_cond (
    .flags_i    (flags_i),
    .cond_sel_i (cond_sel_i),
    .cond_o     (cond_ok)
  );

  agu_rel #(.ADDR_W(ADDR_W), .OFF_W(SREL_W)) u_rel_short (
    .pc_i     (pc_i),
    .off_i    (offset_i[SREL_W-1:0]),
    .target_o (short_pc)
  );

  agu_rel #(.ADDR_W(ADDR_W), .OFF_W(LREL_W)) u_rel_long (
    .pc_i     (pc_i),
    .off_i    (offset_i),
    .target_o (long_pc)
  );

  agu_idx #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_idx (
    .base_i     (base_i),
    .off_i      (offset_i[IDX_W-1:0]),
    .word_i     (size_word_i),
    .ea_o       (idx_ea),
    .misalign_o (idx_mis)
  );

  assign seq_pc = pc_i + ADDR_W'(2);

  always_comb begin
    pc_d    = seq_pc;
    ea_d    = '0;
    taken_d = 1'b0;
    word_d  = 1'b0;
    mis_d   = 1'b0;
    unique case (agu_op_e'(op_i))
      OP_BCC: begin
        taken_d = cond_ok;
        if (cond_ok) pc_d = short_pc;
      end
      OP_BRA: begin
        taken_d = 1'b1;
        pc_d    = long_pc;
      end
      OP_MEM: begin
        ea_d   = idx_ea;
        word_d = size_word_i;
        mis_d  = idx_mis;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o  <= '0;
      taken_o    <= 1'b0;
      ea_o       <= '0;
      ea_word_o  <= 1'b0;
      misalign_o <= 1'b0;
    end else if (valid_i) begin
      next_pc_o  <= pc_d;
      taken_o    <= taken_d;
      ea_o       <= ea_d;
      ea_word_o  <= word_d;
      misalign_o <= mis_d;
    end
  end
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic              size_word_i,
  input logic              valid_o,
  input logic [ADDR_W-1:0] next_pc_o,
  input logic              taken_o,
  input logic [ADDR_W-1:0] ea_o,
  input logic              ea_word_o,
  input logic              misalign_o
);
  // R9
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i));

  // R9
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(next_pc_o) && $stable(ea_o) && $stable(taken_o));

  // R7
  misalign_odd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> ea_word_o && ea_o[0]);

  // R7
  word_odd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'd3 && size_word_i |=> misalign_o == ea_o[0]);

  // R5
  bra_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'd2 |=> taken_o);

  // R6
  mem_seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 2'd3 |=> next_pc_o == $past(pc_i) + ADDR_W'(2) && !taken_o);

  // R10
  non_mem_ea_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i != 2'd3 |=> ea_o == '0 && !ea_word_o && !misalign_o);
endmodule

bind agu_top agu_chk #(.ADDR_W(ADDR_W)) u_agu_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .op_i        (op_i),
  .pc_i        (pc_i),
  .size_word_i (size_word_i),
  .valid_o     (valid_o),
  .next_pc_o   (next_pc_o),
  .taken_o     (taken_o),
  .ea_o        (ea_o),
  .ea_word_o   (ea_word_o),
  .misalign_o  (misalign_o)
);

// File: tb/tb_agu_top.sv
module tb_agu_top;
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] pc;
    logic [9:0]  off;
    logic [3:0]  flags;
    logic [2:0]  sel;
    logic [15:0] base;
    logic        word;
    logic [15:0] e_pc;
    logic        e_tk;
    logic [15:0] e_ea;
    logic        e_wd;
    logic        e_mis;
  } vec_t;

  localparam int NV = 18;
  // R2 R3 R4 R5 R6 R7 R8 R10
  localparam vec_t VECS [NV] = '{
    '{2'd1, 16'h1000, 10'h005, 4'b0000, 3'd0, 16'h0, 1'b0, 16'h100C, 1'b1, 16'h0, 1'b0, 1'b0},
    '{2'd1, 16'h1000, 10'h005, 4'b0001, 3'd0, 16'h0, 1'b0, 16'h1002, 1'b0, 16'h0, 1'b0, 1'b0},
    '{2'd1, 16'h2000, 10'h1FF, 4'b0100, 3'd3, 16'h0, 1'b0, 16'h2000, 1'b1, 16'h0, 1'b0, 1'b0},
    '{2'd1, 16'h2000, 10'h1FF, 4'b0000, 3'd3, 16'h0, 1'b0, 16'h2002, 1'b0, 16'h0, 1'b0, 1'b0},
    '{2'd1, 16'h0100, 10'h100, 4'b0000, 3'd0, 16'h0, 1'b0, 16'hFF02, 1'b1, 16'h0, 1'b0, 1'b0},
    '{2'd1, 16'hFF00, 10'h0FF, 4'b0000, 3'd0, 16'h0, 1'b0, 16'h0100, 1'b1, 16'h0, 1'b0, 1'b0},
    '{2'd1, 16'h3000, 10'h201, 4'b0000, 3'd0, 16'h0, 1'b0, 16'h3004, 1'b1, 16'h0, 1'b0, 1'b0},
    '{2'd1, 16'h0000, 10'h002, 4'b0010, 3'd7, 16'h0, 1'b0, 16'h0006, 1'b1, 16'h0, 1'b0, 1'b0},
    '{2'd1, 16'h0000, 10'h002, 4'b0000, 3'd5, 16'h0, 1'b0, 16'h0002, 1'b0, 16'h0, 1'b0, 1'b0},
    '{2'd1, 16'h0000, 10'h002, 4'b1000, 3'd4, 16'h0, 1'b0, 16'h0002, 1'b0, 16'h0, 1'b0, 1'b0},
    '{2'd1, 16'h0000, 10'h002, 4'b0001, 3'd1, 16'h0, 1'b0, 16'h0006, 1'b1, 16'h0, 1'b0, 1'b0},
    '{2'd2, 16'h1000, 10'h200, 4'b0001, 3'd0, 16'h0, 1'b0, 16'h0C02, 1'b1, 16'h0, 1'b0, 1'b0},
    '{2'd2, 16'h1000, 10'h1FF, 4'b0000, 3'd1, 16'h0, 1'b0, 16'h1400, 1'b1, 16'h0, 1'b0, 1'b0},
    '{2'd3, 16'h0500, 10'h3FF, 4'b0000, 3'd0, 16'h4001, 1'b0, 16'h0502, 1'b0, 16'h4020, 1'b0, 1'b0},
    '{2'd3, 16'h0500, 10'h003, 4'b0000, 3'd0, 16'h4000, 1'b1, 16'h0502, 1'b0, 16'h4003, 1'b1, 1'b1},
    '{2'd3, 16'h0600, 10'h004, 4'b0000, 3'd0, 16'hFFFE, 1'b1, 16'h0602, 1'b0, 16'h0002, 1'b1, 1'b0},
    '{2'd3, 16'h0600, 10'h003, 4'b0000, 3'd0, 16'h4000, 1'b0, 16'h0602, 1'b0, 16'h4003, 1'b0, 1'b0},
    '{2'd0, 16'hFFFE, 10'h3FF, 4'b0000, 3'd0, 16'h1234, 1'b1, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [15:0] pc_i = '0;
  logic [9:0]  offset_i = '0;
  logic [3:0]  flags_i = '0;
  logic [2:0]  cond_sel_i = '0;
  logic [15:0] base_i = '0;
  logic        size_word_i = 1'b0;
  logic        valid_o, taken_o, ea_word_o, misalign_o;
  logic [15:0] next_pc_o, ea_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  agu_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .pc_i(pc_i), .offset_i(offset_i), .flags_i(flags_i), .cond_sel_i(cond_sel_i),
    .base_i(base_i), .size_word_i(size_word_i), .valid_o(valid_o),
    .next_pc_o(next_pc_o), .taken_o(taken_o), .ea_o(ea_o),
    .ea_word_o(ea_word_o), .misalign_o(misalign_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = v.op; pc_i = v.pc; offset_i = v.off;
    flags_i = v.flags; cond_sel_i = v.sel; base_i = v.base; size_word_i = v.word;
    @(posedge clk_i);
    #1;
    valid_i = 1'b0;
  endtask

  task automatic check_vec(input vec_t v, input string tag);
    chk({tag, " next_pc"}, next_pc_o, v.e_pc);
    chk({tag, " taken"}, {15'd0, taken_o}, {15'd0, v.e_tk});
    chk({tag, " ea"}, ea_o, v.e_ea);
    chk({tag, " size"}, {15'd0, ea_word_o}, {15'd0, v.e_wd});
    chk({tag, " misalign"}, {15'd0, misalign_o}, {15'd0, v.e_mis});
    chk({tag, " valid"}, {15'd0, valid_o}, 16'd1);
  endtask

  initial begin
    #1;
    // R1 during reset
    chk("R1 rst valid", {15'd0, valid_o}, 16'd0);
    chk("R1 rst pc", next_pc_o, 16'd0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 post valid", {15'd0, valid_o}, 16'd0);
    chk("R1 post pc", next_pc_o, 16'd0);
    chk("R1 post ea", ea_o, 16'd0);
    chk("R1 post flags", {13'd0, taken_o, ea_word_o, misalign_o}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      check_vec(VECS[i], $sformatf("R2-vec%0d", i));
    end

    // R9 hold while idle, valid_o drops
    drive(VECS[14]);
    @(negedge clk_i);
    op_i = 2'd2; pc_i = 16'h7777; offset_i = 10'h3; base_i = 16'h1111; size_word_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R9 hold pc", next_pc_o, 16'h0502);
    chk("R9 hold ea", ea_o, 16'h4003);
    chk("R9 hold mis", {15'd0, misalign_o}, 16'd1);
    chk("R9 valid low", {15'd0, valid_o}, 16'd0);

    // R9 one-cycle latency: before the edge, old value still shown
    @(negedge clk_i);
    valid_i = 1'b1; op_i = 2'd0; pc_i = 16'h0040;
    #1;
    chk("R9 pre-edge", next_pc_o, 16'h0502);
    @(posedge clk_i);
    #1;
    chk("R9 post-edge", next_pc_o, 16'h0042);
    chk("R10 seq ea", ea_o, 16'h0000);
    valid_i = 1'b0;

    // R1 async reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 async pc", next_pc_o, 16'h0000);
    chk("R1 async valid", {15'd0, valid_o}, 16'd0);
    rst_ni = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule